// File: doc/BRIEF.md
# Functional Unit Issue Controller

This block sits at the decode stage of an in-order pipeline. Four execution units sit behind it: a one-cycle integer unit, and adder, multiplier and divider units that are fully pipelined and take 2, 5 and 19 cycles. Each cycle the block decides whether the decoded instruction may enter its unit. The operands can come from the register file or be forwarded from a result that is being written back in that same cycle. The block also grants the single shared writeback port to whichever unit finishes in that cycle.

A per-register countdown records when each pending destination will be written. A slot shift register records which unit owns the writeback port in each future cycle. An instruction is held only when forwarding cannot supply an operand in time, when its completion cycle is already claimed, or when it would complete ahead of an older write to the same register. A memory-stall request freezes all tracking state for as long as it is held.

Top module: `issue_ctrl`

## Requirements
- R1: After reset nothing is pending. A valid instruction issues at once, both forward selects read 3'b000 and wb_grant is zero.
- R2: Unit codes are 0 integer, 1 adder, 2 multiplier, 3 divider, with latencies 1, 2, 5 and 19. An instruction with a destination that issues in cycle t, with no freeze afterwards, raises wb_grant bit `unit` in cycle t+latency and only then.
- R3: A source whose pending result is written back after the current cycle holds issue low.
- R4: A source whose result is written back in the current cycle does not stall. Its forward select is {1'b1, unit code} of the producer. Otherwise the select is 3'b000, meaning the register file.
- R5: If several in-flight results target one register, the forward select and the stall decision follow the youngest producer only.
- R6: Back-to-back independent instructions to the same unit issue on consecutive cycles.
- R7: An instruction with a destination stalls if another in-flight result already owns its writeback cycle.
- R8: An instruction stalls if its writeback would come no later than a pending writeback to the same destination.
- R9: While mem_stall is high, issue and wb_grant are zero and no countdown or slot advances. When it drops, tracking resumes where it stopped.
- R10: A source whose enable is low causes no stall. An instruction without a destination claims no writeback slot and never produces a grant.
- R11: stall equals dec_valid and not issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_unit | input | 2 | Target unit code |
| dec_rd | input | RW | Destination register |
| dec_rd_en | input | 1 | Instruction writes a destination |
| dec_rs1 | input | RW | First source register |
| dec_rs1_en | input | 1 | First source is used |
| dec_rs2 | input | RW | Second source register |
| dec_rs2_en | input | 1 | Second source is used |
| mem_stall | input | 1 | Freeze request from memory |
| issue | output | 1 | Instruction enters its unit this cycle |
| stall | output | 1 | Instruction is held in decode |
| fwd_sel1 | output | 3 | First operand source select |
| fwd_sel2 | output | 3 | Second operand source select |
| wb_grant | output | 4 | One-hot writeback port owner |

## Verification
Directed sequences cover several cases. A dependent placed right behind each unit's producer separates a true stall from a forward. Two writes to one register followed by a reader tell youngest-first selection apart from oldest-first. A divide followed by a multiply that lands on the same cycle exposes a writeback collision, and a short write behind a long one exposes ordering. A freeze while a result is due shows that the grant is deferred rather than lost. A long pseudo-random stream over a few registers, with random freezes, is then compared every cycle against a behavioural model that uses absolute completion times.

// File: rtl/issue_ctrl.sv
module issue_ctrl #(
  parameter int RW      = 6,
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 5,
  parameter int LAT_DIV = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  input  logic [1:0]    dec_unit,
  input  logic [RW-1:0] dec_rd,
  input  logic          dec_rd_en,
  input  logic [RW-1:0] dec_rs1,
  input  logic          dec_rs1_en,
  input  logic [RW-1:0] dec_rs2,
  input  logic          dec_rs2_en,
  input  logic          mem_stall,
  output logic          issue,
  output logic          stall,
  output logic [2:0]    fwd_sel1,
  output logic [2:0]    fwd_sel2,
  output logic [3:0]    wb_grant
);
  localparam int NREG  = 1 << RW;
  localparam int LM1   = (LAT_INT > LAT_ADD) ? LAT_INT : LAT_ADD;
  localparam int LM2   = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
  localparam int LMAX  = (LM1 > LM2) ? LM1 : LM2;
  localparam int DEPTH = LMAX + 1;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [CW-1:0]    pend  [NREG];
  logic [1:0]       punit [NREG];
  logic [DEPTH-1:0] slot_v;
  logic [1:0]       slot_u [DEPTH];
  logic [CW-1:0]    lat, lat_m1;
  logic             raw1, raw2, waw, conf;

  always_comb begin
    case (dec_unit)
      2'd0:    lat = CW'(LAT_INT);
      2'd1:    lat = CW'(LAT_ADD);
      2'd2:    lat = CW'(LAT_MUL);
      default: lat = CW'(LAT_DIV);
    endcase
  end
  assign lat_m1 = lat - CW'(1);

  assign raw1  = dec_rs1_en && (pend[dec_rs1] > CW'(1));
  assign raw2  = dec_rs2_en && (pend[dec_rs2] > CW'(1));
  assign waw   = dec_rd_en  && (pend[dec_rd] > lat);
  assign conf  = dec_rd_en  && slot_v[lat];
  assign issue = dec_valid && !mem_stall && !(raw1 || raw2 || waw || conf);
  assign stall = dec_valid && !issue;

  assign fwd_sel1 = (dec_rs1_en && pend[dec_rs1] == CW'(1)) ? {1'b1, punit[dec_rs1]} : 3'b000;
  assign fwd_sel2 = (dec_rs2_en && pend[dec_rs2] == CW'(1)) ? {1'b1, punit[dec_rs2]} : 3'b000;
  assign wb_grant = (slot_v[0] && !mem_stall) ? (4'b0001 << slot_u[0]) : 4'b0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        pend[r]  <= '0;
        punit[r] <= '0;
      end
      slot_v <= '0;
      for (int i = 0; i < DEPTH; i++) slot_u[i] <= '0;
    end else if (!mem_stall) begin
      for (int r = 0; r < NREG; r++)
        if (pend[r] != '0) pend[r] <= pend[r] - CW'(1);
      slot_v <= slot_v >> 1;
      for (int i = 0; i < DEPTH - 1; i++) slot_u[i] <= slot_u[i+1];
      slot_u[DEPTH-1] <= '0;
      if (issue && dec_rd_en) begin
        pend[dec_rd]    <= lat;
        punit[dec_rd]   <= dec_unit;
        slot_v[lat_m1]  <= 1'b1;
        slot_u[lat_m1]  <= dec_unit;
      end
    end
  end

  AST_FWD1_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && fwd_sel1[2]) |-> wb_grant[fwd_sel1[1:0]]); // R4
  AST_FWD2_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && fwd_sel2[2]) |-> wb_grant[fwd_sel2[1:0]]); // R4
  AST_INT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_rd_en && dec_unit == 2'd0) |=> (wb_grant[0] || mem_stall)); // R2
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stall |=> $stable(slot_v)); // R9
  AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stall |-> (!issue && wb_grant == 4'b0000)); // R9
endmodule

// File: tb/test_issue_ctrl.sv
module test_issue_ctrl;
  localparam int P = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dec_valid = 0, dec_rd_en = 0, dec_rs1_en = 0, dec_rs2_en = 0, mem_stall = 0;
  logic [1:0] dec_unit = 0;
  logic [5:0] dec_rd = 0, dec_rs1 = 0, dec_rs2 = 0;
  logic issue, stall;
  logic [2:0] fwd_sel1, fwd_sel2;
  logic [3:0] wb_grant;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(P/2) clk = ~clk;

  issue_ctrl i_issue_ctrl (.clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_unit(dec_unit),
    .dec_rd(dec_rd), .dec_rd_en(dec_rd_en), .dec_rs1(dec_rs1), .dec_rs1_en(dec_rs1_en),
    .dec_rs2(dec_rs2), .dec_rs2_en(dec_rs2_en), .mem_stall(mem_stall), .issue(issue),
    .stall(stall), .fwd_sel1(fwd_sel1), .fwd_sel2(fwd_sel2), .wb_grant(wb_grant));

  int rdy [64];
  int pu [64];
  int claim [int];
  int now = 0;

  function automatic int lat(int u);
    case (u) 0: return 1; 1: return 2; 2: return 5; default: return 19; endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(bit v, int u, int rd, bit rde, int s1, bit s1e, int s2, bit s2e, bit ms);
    int e_f1, e_f2, e_wb, l;
    bit e_iss, hz;
    @(negedge clk);
    dec_valid = v; dec_unit = u[1:0]; dec_rd = rd[5:0]; dec_rd_en = rde;
    dec_rs1 = s1[5:0]; dec_rs1_en = s1e; dec_rs2 = s2[5:0]; dec_rs2_en = s2e; mem_stall = ms;
    #1;
    l = lat(u);
    e_f1 = (s1e && rdy[s1] == now) ? 4 + pu[s1] : 0;
    e_f2 = (s2e && rdy[s2] == now) ? 4 + pu[s2] : 0;
    hz = (s1e && rdy[s1] > now) || (s2e && rdy[s2] > now) ||
         (rde && rdy[rd] >= now + l) || (rde && claim.exists(now + l));
    e_iss = v && !ms && !hz;
    e_wb = (!ms && claim.exists(now)) ? (1 << claim[now]) : 0;
    chk(issue == e_iss, "R3 issue", int'(issue), int'(e_iss));
    chk(stall == (v && !e_iss), "R11 stall", int'(stall), int'(v && !e_iss));
    chk(int'(fwd_sel1) == e_f1, "R4 fwd1", int'(fwd_sel1), e_f1);
    chk(int'(fwd_sel2) == e_f2, "R4 fwd2", int'(fwd_sel2), e_f2);
    chk(int'(wb_grant) == e_wb, "R2 wb_grant", int'(wb_grant), e_wb);
    if (!ms) begin
      if (e_iss && rde) begin
        rdy[rd] = now + l; pu[rd] = u; claim[now + l] = u;
      end
      if (claim.exists(now)) claim.delete(now);
      now++;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(P*200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    for (int r = 0; r < 64; r++) begin rdy[r] = -1000; pu[r] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    cyc(1, 0, 1, 1, 2, 1, 3, 1, 0);
    chk(issue == 1'b1, "R1 issue after reset", int'(issue), 1);
    chk(fwd_sel1 == 3'b000 && fwd_sel2 == 3'b000, "R1 fwd after reset", int'(fwd_sel1), 0);
    chk(wb_grant == 4'b0000, "R1 grant after reset", int'(wb_grant), 0);
    idle(3);

    // R2 divider latency
    cyc(1, 3, 10, 1, 0, 0, 0, 0, 0);
    cnt = 0;
    for (int i = 0; i < 25; i++) begin
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
      if (wb_grant[3] && cnt == 0) cnt = i + 1;
    end
    chk(cnt == 19, "R2 divider latency", cnt, 19);

    // R3 / R4 adder dependency
    cyc(1, 1, 1, 1, 0, 0, 0, 0, 0);
    cyc(1, 0, 2, 1, 1, 1, 0, 0, 0);
    chk(stall == 1'b1, "R3 stall behind adder", int'(stall), 1);
    cyc(1, 0, 2, 1, 1, 1, 0, 0, 0);
    chk(issue == 1'b1 && fwd_sel1 == 3'b101, "R4 forward from adder", int'(fwd_sel1), 5);
    idle(3);

    // R6 pipelined multiplier
    for (int i = 0; i < 4; i++) begin
      cyc(1, 2, 40 + i, 1, 0, 0, 0, 0, 0);
      chk(issue == 1'b1, "R6 back-to-back multiply", int'(issue), 1);
    end
    idle(8);

    // R7 writeback slot collision
    cyc(1, 3, 20, 1, 0, 0, 0, 0, 0);
    idle(13);
    cyc(1, 2, 21, 1, 0, 0, 0, 0, 0);
    chk(stall == 1'b1, "R7 slot collision", int'(stall), 1);
    cyc(1, 2, 21, 1, 0, 0, 0, 0, 0);
    chk(issue == 1'b1, "R7 next slot free", int'(issue), 1);
    idle(8);

    // R8 write ordering
    cyc(1, 3, 30, 1, 0, 0, 0, 0, 0);
    cyc(1, 0, 30, 1, 0, 0, 0, 0, 0);
    chk(stall == 1'b1, "R8 younger write would pass older", int'(stall), 1);
    idle(22);

    // R5 youngest producer
    cyc(1, 1, 7, 1, 0, 0, 0, 0, 0);
    cyc(1, 2, 7, 1, 0, 0, 0, 0, 0);
    cyc(1, 0, 8, 1, 0, 0, 7, 1, 0);
    chk(stall == 1'b1 && fwd_sel2 == 3'b000, "R5 older result not forwarded", int'(fwd_sel2), 0);
    cnt = 0;
    while (!issue && cnt < 10) begin cyc(1, 0, 8, 1, 0, 0, 7, 1, 0); cnt++; end
    chk(fwd_sel2 == 3'b110, "R5 youngest forwarded", int'(fwd_sel2), 6);
    idle(6);

    // R9 freeze with result due
    cyc(1, 0, 2, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      cyc(1, 0, 3, 1, 2, 1, 0, 0, 1);
      chk(issue == 1'b0 && wb_grant == 4'b0000, "R9 frozen", int'(wb_grant), 0);
    end
    cyc(1, 0, 3, 1, 2, 1, 0, 0, 0);
    chk(issue == 1'b1 && fwd_sel1 == 3'b100 && wb_grant == 4'b0001, "R9 resume", int'(wb_grant), 1);
    idle(4);

    // R10 disabled source and no destination
    cyc(1, 3, 12, 1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 12, 0, 12, 0, 0);
    chk(issue == 1'b1, "R10 disabled sources ignored", int'(issue), 1);
    cyc(1, 2, 13, 0, 0, 0, 0, 0, 0);
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
      if (wb_grant[2]) cnt++;
    end
    chk(cnt == 0, "R10 no grant without destination", cnt, 0);
    idle(20);

    // mixed random stream
    for (int i = 0; i < 600; i++)
      cyc(($urandom % 10) < 8, $urandom % 4, $urandom % 8, ($urandom % 8) != 0,
          $urandom % 8, $urandom % 2, $urandom % 8, $urandom % 2, ($urandom % 10) == 0);
    idle(25);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule